// File: doc/BRIEF.md
# SDRAM Bank Timing Gate

This block sits between a command source and the control and address pins of an SDRAM device. It keeps a record for each bank: whether the bank is open and how many cycles have passed since that bank was last opened and last closed. It also counts the cycles since the most recent open of any bank. Each incoming request carries a command (open a row, read, write or close), a bank, a row and a column. The request is accepted only when every timing rule for that bank and command is met. Otherwise ready stays low and the pins carry a no-operation.

Accepted commands appear on the pins in the cycle after the handshake. The gate also raises a per-bank warning once a bank has been open for the longest time allowed, so that a scheduler can close it. Refresh, data capture, burst counting and power modes are handled elsewhere.

Top module: `sdram_cmd_gate`

## Requirements
- R1: While reset is held and after it is released, the pins carry a no-operation (chip select low, row strobe, column strobe and write enable high, bank 0, address 0), and no warning is raised.
- R2: A read or write to a bank that is not open is never accepted.
- R3: A read or write to a bank is accepted no earlier than T_RCD cycles after the handshake that opened that bank. When it is requested right after the open, it stalls exactly T_RCD-1 cycles.
- R4: Two opens of the same bank are accepted at least T_RC cycles apart.
- R5: Two opens of any banks are accepted at least T_RRD cycles apart. An open to a second bank requested right after an open stalls T_RRD-1 cycles.
- R6: An open to a bank that is already open is never accepted. A different row needs a close first.
- R7: A close of an open bank is accepted no earlier than T_RAS_MIN cycles after its open. A close of a bank that is not open is accepted at once and changes no timing state.
- R8: An open of a bank is accepted no earlier than T_RP cycles after the close of that bank.
- R9: overActive[b] is high exactly while bank b is open and at least T_RAS_MAX cycles have passed since the handshake that opened it. It clears in the cycle after its close is accepted.
- R10: A command accepted at a rising edge drives the pins during the following cycle. The encodings, as {csN,rasN,casN,weN}, are: open 0011, with the address set to the row; read 0101 and write 0100, with the address set to the column (bit 10 low); close 0010, with the address 0. The request command codes are 0 open, 1 read, 2 write, 3 close.
- R11: Column commands to open banks that have passed T_RCD are accepted on consecutive cycles, to the same bank or to different banks.
- R12: ready depends only on the current request fields and the timing state. When a valid request is not accepted, the next cycle's pins carry a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request meets all timing rules this cycle |
| reqCmd | input | 2 | 0 open, 1 read, 2 write, 3 close |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ADDR_W | Row for an open |
| reqCol | input | COL_W | Starting column for read or write |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBank | output | BANK_W | Bank select |
| sdAddr | output | ADDR_W | Address pins |
| overActive | output | NUM_BANKS | Per-bank open-too-long warning |

## Verification
The checker rebuilds the bank states from the pins alone. Its properties therefore assume that nothing besides this gate drives commands to the device, and that the timing parameters satisfy T_RCD, T_RC, T_RRD, T_RAS_MIN and T_RP no greater than T_RAS_MAX. The checker places no constraint on reqValid. The stimulus drops requests that are still stalled and sends random commands to random banks, so acceptance is decided only by the timing state. The bench parameters follow the ordering rule above, and T_RAS_MAX is set small enough that the warning is reached within the run.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;

  typedef enum logic [1:0] {
    CMD_ACT   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_PRE   = 2'd3
  } gateCmd_e;

  // strobes from control to datapath, valid in the handshake cycle
  typedef struct packed {
    logic actFire;
    logic colFire;
    logic preFire;
    logic isWrite;
  } gateStrobe_t;

endpackage

// File: rtl/sdram_bank_timers.sv
module sdram_bank_timers
  import sdram_gate_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 10,
  parameter int T_RRD     = 2,
  parameter int T_RAS_MIN = 6,
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 10000,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(T_RAS_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStrobe_t          strobe,
  input  logic [BANK_W-1:0]    bankSel,
  output logic [NUM_BANKS-1:0] canAct,
  output logic [NUM_BANKS-1:0] canCol,
  output logic [NUM_BANKS-1:0] canPre,
  output logic [NUM_BANKS-1:0] overActive
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(T_RAS_MAX);
  localparam logic [CNT_W-1:0] RCD_L   = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] RC_L    = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] RRD_L   = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] RASN_L  = CNT_W'(T_RAS_MIN);
  localparam logic [CNT_W-1:0] RP_L    = CNT_W'(T_RP);

  logic [CNT_W-1:0] sinceAnyAct;

  // cycles since the most recent open of any bank, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAnyAct <= CNT_MAX;
    end else if (strobe.actFire) begin
      sinceAnyAct <= CNT_W'(1);
    end else if (sinceAnyAct < CNT_MAX) begin
      sinceAnyAct <= sinceAnyAct + CNT_W'(1);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             active;
    logic [CNT_W-1:0] sinceAct;
    logic [CNT_W-1:0] sincePre;
    logic             hit;

    assign hit = (bankSel == BANK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        active   <= 1'b0;
        sinceAct <= CNT_MAX;
        sincePre <= CNT_MAX;
      end else begin
        if (strobe.actFire && hit) begin
          active   <= 1'b1;
          sinceAct <= CNT_W'(1);
        end else if (sinceAct < CNT_MAX) begin
          sinceAct <= sinceAct + CNT_W'(1);
        end
        // a close of an idle bank leaves the timers alone
        if (strobe.preFire && hit && active) begin
          active   <= 1'b0;
          sincePre <= CNT_W'(1);
        end else if (sincePre < CNT_MAX) begin
          sincePre <= sincePre + CNT_W'(1);
        end
      end
    end

    assign canAct[b]     = !active && (sincePre >= RP_L) && (sinceAct >= RC_L)
                           && (sinceAnyAct >= RRD_L);
    assign canCol[b]     = active && (sinceAct >= RCD_L);
    assign canPre[b]     = !active || (sinceAct >= RASN_L);
    assign overActive[b] = active && (sinceAct >= CNT_MAX);
  end

endmodule

// File: rtl/sdram_gate_ctrl.sv
module sdram_gate_ctrl
  import sdram_gate_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 reqValid,
  input  gateCmd_e             reqCmd,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [NUM_BANKS-1:0] canAct,
  input  logic [NUM_BANKS-1:0] canCol,
  input  logic [NUM_BANKS-1:0] canPre,
  output logic                 reqReady,
  output gateStrobe_t          strobe
);

  logic legal;
  logic fire;

  always_comb begin
    unique case (reqCmd)
      CMD_ACT:             legal = canAct[reqBank];
      CMD_READ, CMD_WRITE: legal = canCol[reqBank];
      default:             legal = canPre[reqBank];
    endcase
    fire           = reqValid && legal;
    strobe.actFire = fire && (reqCmd == CMD_ACT);
    strobe.colFire = fire && ((reqCmd == CMD_READ) || (reqCmd == CMD_WRITE));
    strobe.preFire = fire && (reqCmd == CMD_PRE);
    strobe.isWrite = (reqCmd == CMD_WRITE);
  end

  assign reqReady = legal;

endmodule

// File: rtl/sdram_pin_drive.sv
module sdram_pin_drive
  import sdram_gate_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBank,
  output logic [ADDR_W-1:0] sdAddr
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdCsN  <= 1'b0;
      sdRasN <= 1'b1;
      sdCasN <= 1'b1;
      sdWeN  <= 1'b1;
      sdBank <= '0;
      sdAddr <= '0;
    end else begin
      sdCsN  <= 1'b0;
      sdRasN <= 1'b1;
      sdCasN <= 1'b1;
      sdWeN  <= 1'b1;
      sdBank <= '0;
      sdAddr <= '0;
      if (strobe.actFire) begin
        sdRasN <= 1'b0;
        sdBank <= reqBank;
        sdAddr <= reqRow;
      end else if (strobe.colFire) begin
        sdCasN <= 1'b0;
        sdWeN  <= !strobe.isWrite;
        sdBank <= reqBank;
        sdAddr <= ADDR_W'(reqCol);
      end else if (strobe.preFire) begin
        sdRasN <= 1'b0;
        sdWeN  <= 1'b0;
        sdBank <= reqBank;
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
  import sdram_gate_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 8,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 10,
  parameter int T_RRD     = 2,
  parameter int T_RAS_MIN = 6,
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 10000,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [1:0]           reqCmd,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ADDR_W-1:0]    reqRow,
  input  logic [COL_W-1:0]     reqCol,
  output logic                 sdCsN,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [BANK_W-1:0]    sdBank,
  output logic [ADDR_W-1:0]    sdAddr,
  output logic [NUM_BANKS-1:0] overActive
);

  gateStrobe_t          strobe;
  logic [NUM_BANKS-1:0] canAct;
  logic [NUM_BANKS-1:0] canCol;
  logic [NUM_BANKS-1:0] canPre;

  sdram_gate_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .reqValid (reqValid),
    .reqCmd   (gateCmd_e'(reqCmd)),
    .reqBank  (reqBank),
    .canAct   (canAct),
    .canCol   (canCol),
    .canPre   (canPre),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  sdram_bank_timers #(
    .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD),
    .T_RAS_MIN(T_RAS_MIN), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
  ) u_timers (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bankSel    (reqBank),
    .canAct     (canAct),
    .canCol     (canCol),
    .canPre     (canPre),
    .overActive (overActive)
  );

  sdram_pin_drive #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .COL_W(COL_W)
  ) u_pins (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqBank (reqBank),
    .reqRow  (reqRow),
    .reqCol  (reqCol),
    .sdCsN   (sdCsN),
    .sdRasN  (sdRasN),
    .sdCasN  (sdCasN),
    .sdWeN   (sdWeN),
    .sdBank  (sdBank),
    .sdAddr  (sdAddr)
  );

endmodule

// File: rtl/sdram_gate_chk.sv
module sdram_gate_chk #(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RC      = 10,
  parameter int T_RRD     = 2,
  parameter int T_RAS_MIN = 6,
  parameter int T_RP      = 3,
  parameter int T_RAS_MAX = 10000,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int AGE_W    = $clog2(T_RAS_MAX + 1) + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 sdCsN,
  input logic                 sdRasN,
  input logic                 sdCasN,
  input logic                 sdWeN,
  input logic [BANK_W-1:0]    sdBank,
  input logic [NUM_BANKS-1:0] overActive
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic pAct, pCol, pPre, pNop;
  assign pAct = !sdCsN && !sdRasN &&  sdCasN &&  sdWeN;
  assign pCol = !sdCsN &&  sdRasN && !sdCasN;
  assign pPre = !sdCsN && !sdRasN &&  sdCasN && !sdWeN;
  assign pNop = !sdCsN &&  sdRasN &&  sdCasN &&  sdWeN;

  logic [NUM_BANKS-1:0] chkActive;
  logic [AGE_W-1:0]     actAge [NUM_BANKS];
  logic [AGE_W-1:0]     preAge [NUM_BANKS];
  logic [AGE_W-1:0]     anyAge;

  // bank state rebuilt from the pins alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkActive <= '0;
      anyAge    <= AGE_MAX;
      for (int b = 0; b < NUM_BANKS; b++) begin
        actAge[b] <= AGE_MAX;
        preAge[b] <= AGE_MAX;
      end
    end else begin
      anyAge <= pAct ? AGE_W'(1) : ((anyAge == AGE_MAX) ? anyAge : anyAge + AGE_W'(1));
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (pAct && sdBank == BANK_W'(b)) begin
          chkActive[b] <= 1'b1;
          actAge[b]    <= AGE_W'(1);
        end else if (actAge[b] != AGE_MAX) begin
          actAge[b] <= actAge[b] + AGE_W'(1);
        end
        if (pPre && sdBank == BANK_W'(b) && chkActive[b]) begin
          chkActive[b] <= 1'b0;
          preAge[b]    <= AGE_W'(1);
        end else if (preAge[b] != AGE_MAX) begin
          preAge[b] <= preAge[b] + AGE_W'(1);
        end
      end
    end
  end

  // R12
  stall_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> pNop);

  // R5
  act_spacing_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    pAct |-> (anyAge >= AGE_W'(T_RRD)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankChk
    // R2
    col_needs_open_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pCol && sdBank == BANK_W'(b)) |-> chkActive[b]);
    // R3
    col_after_rcd_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pCol && sdBank == BANK_W'(b)) |-> (actAge[b] >= AGE_W'(T_RCD)));
    // R4
    act_same_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pAct && sdBank == BANK_W'(b)) |-> (actAge[b] >= AGE_W'(T_RC)));
    // R6
    act_idle_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pAct && sdBank == BANK_W'(b)) |-> !chkActive[b]);
    // R7
    pre_after_rasmin_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pPre && sdBank == BANK_W'(b) && chkActive[b]) |-> (actAge[b] >= AGE_W'(T_RAS_MIN)));
    // R8
    act_after_rp_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pAct && sdBank == BANK_W'(b)) |-> (preAge[b] >= AGE_W'(T_RP)));
    // R9
    warn_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
      overActive[b] |-> (chkActive[b] && actAge[b] >= AGE_W'(T_RAS_MAX - 1)));
  end

endmodule

bind sdram_cmd_gate sdram_gate_chk #(
  .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD),
  .T_RAS_MIN(T_RAS_MIN), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_gateChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .sdCsN      (sdCsN),
  .sdRasN     (sdRasN),
  .sdCasN     (sdCasN),
  .sdWeN      (sdWeN),
  .sdBank     (sdBank),
  .overActive (overActive)
);

// File: tb/test_sdram_cmd_gate.sv
module test_sdram_cmd_gate;

  localparam int NB = 4, AW = 12, CW = 8;
  localparam int T_RCD = 3, T_RC = 10, T_RRD = 2, T_RAS_MIN = 6, T_RP = 3, T_RAS_MAX = 30;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqReady;
  logic [1:0]    reqCmd = '0;
  logic [1:0]    reqBank = '0;
  logic [AW-1:0] reqRow = '0;
  logic [CW-1:0] reqCol = '0;
  logic sdCsN, sdRasN, sdCasN, sdWeN;
  logic [1:0]    sdBank;
  logic [AW-1:0] sdAddr;
  logic [NB-1:0] overActive;

  sdram_cmd_gate #(
    .NUM_BANKS(NB), .ADDR_W(AW), .COL_W(CW), .T_RCD(T_RCD), .T_RC(T_RC),
    .T_RRD(T_RRD), .T_RAS_MIN(T_RAS_MIN), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
  ) i_sdram_cmd_gate (.*);

  int checks = 0, fails = 0;

  // reference model: edge numbers of events
  int edgeN = 0;
  int lastAct[NB], lastPre[NB], lastAny;
  bit open_[NB];
  logic [3:0]    expCtl = 4'b0111;
  logic [1:0]    expBa = '0;
  logic [AW-1:0] expAddr = '0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit legal(int cmd, int b);
    case (cmd)
      0: return !open_[b] && (edgeN - lastPre[b] >= T_RP) &&
                (edgeN - lastAct[b] >= T_RC) && (edgeN - lastAny >= T_RRD);
      1, 2: return open_[b] && (edgeN - lastAct[b] >= T_RCD);
      default: return !open_[b] || (edgeN - lastAct[b] >= T_RAS_MIN);
    endcase
  endfunction

  // called at a falling edge; leaves at the next falling edge
  task automatic step(bit v, int cmd, int b, int row, int col, string tag, output bit fired);
    bit l;
    logic [NB-1:0] expWarn;
    reqValid = v; reqCmd = 2'(cmd); reqBank = 2'(b); reqRow = AW'(row); reqCol = CW'(col);
    #1;
    l = legal(cmd, b);
    chk(tag, "ready", reqReady, l);
    chk(tag, "ctl", {sdCsN, sdRasN, sdCasN, sdWeN}, expCtl);
    chk(tag, "bank", sdBank, expBa);
    chk(tag, "addr", sdAddr, expAddr);
    for (int i = 0; i < NB; i++) expWarn[i] = open_[i] && (edgeN - lastAct[i] >= T_RAS_MAX);
    chk(tag, "warn", overActive, expWarn);
    fired = v && l;
    expCtl = 4'b0111; expBa = '0; expAddr = '0;
    if (fired) begin
      expBa = 2'(b);
      case (cmd)
        0: begin expCtl = 4'b0011; expAddr = AW'(row); open_[b] = 1; lastAct[b] = edgeN; lastAny = edgeN; end
        1: begin expCtl = 4'b0101; expAddr = AW'(col); end
        2: begin expCtl = 4'b0100; expAddr = AW'(col); end
        default: begin
          expCtl = 4'b0010;
          if (open_[b]) begin open_[b] = 0; lastPre[b] = edgeN; end
        end
      endcase
    end
    edgeN++;
    @(negedge clk);
  endtask

  task automatic issue(int cmd, int b, int row, int col, string tag, output int waits);
    bit f = 0;
    waits = 0;
    while (!f && waits < 60) begin
      step(1, cmd, b, row, col, tag, f);
      if (!f) waits++;
    end
  endtask

  task automatic hold(int cmd, int b, int n, string tag);
    bit f;
    for (int i = 0; i < n; i++) begin
      step(1, cmd, b, 7, 9, tag, f);
      chk(tag, "stalled", f, 0);
    end
  endtask

  task automatic idle(int n, string tag);
    bit f;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag, f);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int w;
    bit f;
    for (int i = 0; i < NB; i++) begin lastAct[i] = -1000; lastPre[i] = -1000; open_[i] = 0; end
    lastAny = -1000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ctl in reset", {sdCsN, sdRasN, sdCasN, sdWeN}, 4'b0111);
    chk("R1", "warn in reset", overActive, 0);
    rstN = 1'b1;
    idle(2, "R1");

    hold(1, 0, 3, "R2");                        // read to closed bank
    hold(2, 3, 2, "R2");                        // write to closed bank
    issue(0, 0, 12'h123, 0, "R10", w);
    chk("R10", "act waits", w, 0);
    issue(1, 0, 0, 8'h45, "R3", w);
    chk("R3", "read waits after open", w, T_RCD - 1);
    issue(0, 2, 12'h0AA, 0, "R10", w);
    issue(0, 3, 12'h055, 0, "R5", w);
    chk("R5", "open-to-open waits", w, T_RRD - 1);
    hold(0, 0, 3, "R6");                        // open bank reopened
    issue(0, 1, 12'h777, 0, "R10", w);
    idle(T_RCD, "R11");
    issue(2, 0, 0, 8'h10, "R11", w); chk("R11", "b2b wr b0", w, 0);
    issue(1, 1, 0, 8'h11, "R11", w); chk("R11", "b2b rd b1", w, 0);
    issue(2, 2, 0, 8'h12, "R11", w); chk("R11", "b2b wr b2", w, 0);
    issue(1, 3, 0, 8'h13, "R11", w); chk("R11", "b2b rd b3", w, 0);
    issue(1, 3, 0, 8'hFF, "R11", w); chk("R11", "b2b rd b3 again", w, 0);

    issue(3, 2, 0, 0, "R7", w);  chk("R7", "close old bank", w, 0);
    issue(3, 2, 0, 0, "R7", w);  chk("R7", "close idle bank", w, 0);
    issue(0, 2, 12'h0BB, 0, "R8", w);
    chk("R8", "open after close", w, T_RP - 2);

    issue(3, 0, 0, 0, "R7", w);
    issue(0, 0, 12'h321, 0, "R8", w);
    issue(3, 0, 0, 0, "R7", w);
    chk("R7", "close after open", w, T_RAS_MIN - 1);
    issue(0, 0, 12'h456, 0, "R4", w);
    chk("R4", "reopen same bank", w,
        ((T_RP > T_RC - T_RAS_MIN) ? T_RP : T_RC - T_RAS_MIN) - 1);

    idle(T_RAS_MAX + 2, "R9");
    chk("R9", "warn bank0 set", overActive[0], 1);
    issue(3, 0, 0, 0, "R9", w);
    step(0, 0, 0, 0, 0, "R9", f);
    chk("R9", "warn bank0 cleared", overActive[0], 0);

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, int'($urandom % 4), int'($urandom % NB),
           int'($urandom % 4096), int'($urandom % 256), "R12", f);
    end
    idle(2, "R12");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule